// File: doc/BRIEF.md
# Stereo Peak Level Hold Meter

This block sits after the decimation path of a two-channel audio converter and watches the signed samples of the left and right channels. Every valid sample is turned into a 6-bit attenuation code with 1 dB per step, where 0 means full scale and larger codes mean quieter signals. Each channel keeps the loudest code it has seen, which is the numerically smallest one. When tracking is disabled, both held codes are forced to the quietest value.

A simple read port returns one 32-bit status word per channel. A read strobe with a channel select latches the word into a register, and the word appears on the next cycle. A read also clears that channel's hold, so a meter driver that polls the block sees the peak of each interval between polls.

Top module: `stereo_peak_hold`

## Requirements
- R1: The level code of a sample is the number of thresholds T_k (k = 1..63) with |x|·2^16 < T_k. The thresholds are T_0 = 2^(W-1+16) and T_k = floor(T_{k-1}·58409 / 2^16), so each step is about 1 dB.
- R2: The most negative sample gives code 0. A magnitude below the lowest threshold (for example 0) saturates to code 63.
- R3: While tracking is enabled, a valid sample replaces the held code only when its code is smaller, so the hold keeps the loudest level since the last clear.
- R4: The left and right channels are held independently, and reading one channel does not change the other channel's hold.
- R5: After reset the held codes are 63 and rd_data is zero.
- R6: While track_en is 0, both held codes are forced to 63 and samples have no effect. This holds even after tracking is enabled again.
- R7: rd_data is registered. It takes the selected channel's word on the cycle after rd_stb, and it stays unchanged while rd_stb is low.
- R8: In the read word, bits 5:0 hold the code and bits 15:12 hold the channel ID: 3 for left (rd_sel = 0) and 4 for right (rd_sel = 1). Bits 11:6 and 31:16 are zero.
- R9: Reading a channel resets its held code to 63.
- R10: When a read and a valid sample of the same channel fall in the same cycle, the read returns the old held code, and the hold restarts from the new sample's code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| track_en | input | 1 | Peak tracking enable |
| smp_valid | input | 1 | Qualifies both sample inputs |
| smp_left | input | W | Left sample, two's complement |
| smp_right | input | W | Right sample, two's complement |
| rd_stb | input | 1 | Read strobe, one cycle |
| rd_sel | input | 1 | Channel select, 0 = left, 1 = right |
| rd_data | output | 32 | Registered status word |

## Verification
A sample presented with smp_valid updates the hold at the next rising edge. A strobe latches rd_data at the rising edge where it is seen, so the word is valid one cycle later. The bench changes inputs on falling edges and, for a read, samples rd_data on the next falling edge. That edge comes after exactly one rising edge, so each result is compared in the cycle it is due. For the same-cycle read-and-sample case, the bench reads again afterwards to observe the restarted hold through the port.

// File: rtl/spk_pkg.sv
package spk_pkg;
  // Fixed-point factor for a 1 dB step: 10^(-1/20) in Q16
  localparam longint unsigned STEP_Q16 = 64'd58409;
  localparam int FRAC = 16;

  // Threshold k in the chain that starts at full scale, scaled by 2^FRAC
  function automatic logic [63:0] thr_calc(input int w, input int k);
    logic [63:0] t;
    t = 64'(1) << (w - 1 + FRAC);
    for (int i = 1; i <= k; i++) t = (t * STEP_Q16) >> 16;
    return t;
  endfunction
endpackage

// File: rtl/spk_level_enc.sv
module spk_level_enc #(
  parameter int W  = 24,
  parameter int CW = 6
) (
  input  logic [W-1:0]  smp,
  output logic [CW-1:0] code
);
  import spk_pkg::*;
  localparam int NTHR = 2**CW - 1;
  localparam int MW   = W + FRAC;

  logic [W-1:0]    mag;
  logic [MW-1:0]   magx;
  logic [NTHR-1:0] below;

  always_comb begin
    mag  = smp[W-1] ? (~smp + 1'b1) : smp;
    magx = {mag, {FRAC{1'b0}}};
  end

  for (genvar k = 1; k <= NTHR; k++) begin : g_thr
    localparam logic [63:0] TK = thr_calc(W, k);
    assign below[k-1] = 64'(magx) < TK;
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < NTHR; i++) code = code + CW'(below[i]);
  end
endmodule

// File: rtl/spk_hold_chan.sv
module spk_hold_chan #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          upd,
  input  logic          clr,
  input  logic [CW-1:0] code_in,
  output logic [CW-1:0] hold
);
  localparam logic [CW-1:0] QUIET = '1;

  always_ff @(posedge clk) begin
    if (rst || !en)              hold <= QUIET;
    else if (clr)                hold <= upd ? code_in : QUIET;
    else if (upd && code_in < hold) hold <= code_in;
  end
endmodule

// File: rtl/spk_read_port.sv
module spk_read_port #(
  parameter int CW   = 6,
  parameter int DW   = 32,
  parameter int IDW  = 4,
  parameter int IDLO = 12,
  parameter logic [IDW-1:0] ID_L = 4'd3,
  parameter logic [IDW-1:0] ID_R = 4'd4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_stb,
  input  logic          rd_sel,
  input  logic [CW-1:0] hold_l,
  input  logic [CW-1:0] hold_r,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] word;

  always_comb begin
    word = '0;
    word[IDLO +: IDW] = rd_sel ? ID_R : ID_L;
    word[CW-1:0]      = rd_sel ? hold_r : hold_l;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_stb) rd_data <= word;
  end
endmodule

// File: rtl/stereo_peak_hold.sv
module stereo_peak_hold #(
  parameter int W  = 24,
  parameter int CW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          track_en,
  input  logic          smp_valid,
  input  logic [W-1:0]  smp_left,
  input  logic [W-1:0]  smp_right,
  input  logic          rd_stb,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data
);
  localparam int NCH = 2;

  logic [W-1:0]  samp   [NCH];
  logic [CW-1:0] code   [NCH];
  logic [CW-1:0] hold_q [NCH];

  assign samp[0] = smp_left;
  assign samp[1] = smp_right;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    spk_level_enc #(.W(W), .CW(CW)) u_enc (
      .smp  (samp[ch]),
      .code (code[ch])
    );
    spk_hold_chan #(.CW(CW)) u_hold (
      .clk     (clk),
      .rst     (rst),
      .en      (track_en),
      .upd     (smp_valid),
      .clr     (rd_stb && (rd_sel == 1'(ch))),
      .code_in (code[ch]),
      .hold    (hold_q[ch])
    );
  end

  spk_read_port #(.CW(CW), .DW(DW)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_stb  (rd_stb),
    .rd_sel  (rd_sel),
    .hold_l  (hold_q[0]),
    .hold_r  (hold_q[1]),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/spk_checker.sv
module spk_checker #(
  parameter int W  = 24,
  parameter int CW = 6,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          track_en,
  input logic          smp_valid,
  input logic [W-1:0]  smp_left,
  input logic          rd_stb,
  input logic          rd_sel,
  input logic [DW-1:0] rd_data,
  input logic [CW-1:0] hold_l,
  input logic [CW-1:0] hold_r
);
  localparam logic [CW-1:0] QUIET = '1;
  localparam logic [W-1:0]  MOST_NEG = {1'b1, {(W-1){1'b0}}};

  // R6
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !track_en |=> (hold_l == QUIET && hold_r == QUIET));
  // R3
  p_no_rise_r3: assert property (@(posedge clk) disable iff (rst)
    (track_en && !(rd_stb && !rd_sel)) |=> hold_l <= $past(hold_l));
  // R9
  p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (track_en && rd_stb && !rd_sel && !smp_valid) |=> hold_l == QUIET);
  // R2
  p_fullscale_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (track_en && smp_valid && smp_left == MOST_NEG) |=> hold_l == '0);
  // R8
  p_word_zeros_r8: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> (rd_data[DW-1:16] == '0 && rd_data[11:CW] == '0));
  // R8
  p_word_id_r8: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rd_data[15:12] == ($past(rd_sel) ? 4'd4 : 4'd3));
  // R10
  p_read_old_value_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !rd_sel) |=> rd_data[CW-1:0] == $past(hold_l));
  // R7
  p_data_kept_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));
endmodule

bind stereo_peak_hold spk_checker #(.W(W), .CW(CW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .track_en  (track_en),
  .smp_valid (smp_valid),
  .smp_left  (smp_left),
  .rd_stb    (rd_stb),
  .rd_sel    (rd_sel),
  .rd_data   (rd_data),
  .hold_l    (hold_q[0]),
  .hold_r    (hold_q[1])
);

// File: tb/stereo_peak_hold_bench.sv
module stereo_peak_hold_bench;
  localparam int CLK_P = 10;
  localparam int W  = 12;
  localparam int CW = 6;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          track_en = 1'b0;
  logic          smp_valid = 1'b0;
  logic [W-1:0]  smp_left = '0;
  logic [W-1:0]  smp_right = '0;
  logic          rd_stb = 1'b0;
  logic          rd_sel = 1'b0;
  logic [DW-1:0] rd_data;

  int total = 0;
  int bad = 0;
  bit done = 0;
  longint thr [64];

  always #(CLK_P/2) clk = ~clk;

  stereo_peak_hold #(.W(W), .CW(CW), .DW(DW)) u_stereo_peak_hold (
    .clk(clk), .rst(rst), .track_en(track_en), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right), .rd_stb(rd_stb),
    .rd_sel(rd_sel), .rd_data(rd_data));

  task automatic check(input string req, input longint got, input longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int ref_code(input int v);
    longint m;
    int c;
    m = (v < 0 ? -v : v) * 65536;
    c = 0;
    for (int k = 1; k <= 63; k++) if (m < thr[k]) c++;
    return c;
  endfunction

  task automatic do_sample(input int l, input int r);
    @(negedge clk);
    smp_valid = 1'b1; smp_left = W'(l); smp_right = W'(r);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic do_read(input logic sel, output logic [DW-1:0] w);
    @(negedge clk);
    rd_stb = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_stb = 1'b0;
    w = rd_data;
  endtask

  function automatic bit fmt_ok(input logic [DW-1:0] w, input int id);
    return (w[31:16] == 0) && (w[11:6] == 0) && (int'(w[15:12]) == id);
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] w;
    int c1, c2, m;
    thr[0] = longint'(1) << (W - 1 + 16);
    for (int k = 1; k < 64; k++) thr[k] = (thr[k-1] * 58409) >>> 16;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R5 rd_data after reset", rd_data, 0);
    track_en = 1'b1;
    do_read(1'b0, w); check("R5 left hold after reset", w[5:0], 63);
    do_read(1'b1, w); check("R5 right hold after reset", w[5:0], 63);

    // R1 R8 sweep over every sample value
    for (int v = -(1 << (W-1)); v < (1 << (W-1)); v++) begin
      do_sample(v, -1 - v);
      do_read(1'b0, w);
      check("R1 left code", w[5:0], ref_code(v));
      check("R8 left word format", fmt_ok(w, 3), 1);
      do_read(1'b1, w);
      check("R1 right code", w[5:0], ref_code(-1 - v));
      check("R8 right word format", fmt_ok(w, 4), 1);
    end

    // R2 endpoints
    do_sample(-(1 << (W-1)), 0);
    do_read(1'b0, w); check("R2 most negative", w[5:0], 0);
    do_read(1'b1, w); check("R2 zero saturates", w[5:0], 63);

    // R3 keeps loudest, R9 clears on read
    do_sample(1000, 0); do_sample(2000, 0); do_sample(300, 0);
    m = ref_code(2000);
    do_read(1'b0, w); check("R3 loudest kept", w[5:0], m);
    do_read(1'b0, w); check("R9 cleared after read", w[5:0], 63);

    // R4 independence
    do_sample(2047, 10);
    do_read(1'b1, w); check("R4 right own level", w[5:0], ref_code(10));
    do_read(1'b0, w); check("R4 left kept across right read", w[5:0], ref_code(2047));

    // R6 disabled
    track_en = 1'b0;
    do_sample(-2048, -2048);
    do_read(1'b0, w); check("R6 disabled left reads quiet", w[5:0], 63);
    @(negedge clk); track_en = 1'b1;
    do_read(1'b1, w); check("R6 right quiet after re-enable", w[5:0], 63);

    // R7 data held while strobe low
    do_sample(500, 0);
    do_read(1'b0, w);
    c1 = ref_code(500);
    check("R7 read value", w[5:0], c1);
    do_sample(-2048, -2048); do_sample(1, 1);
    @(negedge clk);
    check("R7 rd_data unchanged without strobe", rd_data, longint'(w));

    // R10 read and sample in the same cycle
    do_read(1'b0, w); do_read(1'b1, w);
    do_sample(100, 0);
    c1 = ref_code(100);
    c2 = ref_code(50);
    @(negedge clk);
    rd_stb = 1'b1; rd_sel = 1'b0; smp_valid = 1'b1; smp_left = W'(50);
    @(negedge clk);
    rd_stb = 1'b0; smp_valid = 1'b0;
    check("R10 read returns old hold", rd_data[5:0], c1);
    do_read(1'b0, w); check("R10 hold restarted from same-cycle sample", w[5:0], c2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule